// File: doc/BRIEF.md
# Conversion Result Serializer with Parity Status Byte

This block hands a finished 24-bit conversion result to a host over a four-wire, SPI-like shift port. The host selects the block by pulling its active-low select line low. On that clock the block freezes the conversion word together with a status byte. The host then clocks the bits out with a serial clock that idles high. A new bit appears after each falling serial clock edge, and the host samples it on the following rising edge.

Two control bits shape the frame. Status-append extends the frame from 24 to 32 bits by adding the status byte after the data. Parity-enable puts an even-parity bit into that status byte, which lets the host catch a single corrupted bit. Parity has effect only when status-append is also set, because the bit can reach the host only inside the status byte. A data-ready output tells the host when a result is waiting and no read is in progress.

The serial clock and select inputs are taken as already synchronous to the block clock `clk`. Each phase of the serial clock lasts at least two `clk` periods.

Top module: `rdout_serializer`

## Requirements
- R1: After the host selects the block, bits are sent MSB first. Each bit is driven out in the first `clk` cycle after a falling serial clock edge is seen. It is held until the next falling edge.
- R2: With status-append set (`sta_en_i`=1), a read is 32 bits: the 24 data bits, then the status byte sent MSB first. In the status byte, bit 7 is the not-ready flag, bits 6:5 are 0, bit 4 is parity and bits 3:0 are the channel index.
- R3: With both `par_en_i` and `sta_en_i` set, the parity bit is chosen so that the number of 1s across the 24 data bits and the parity bit is even. A word with eleven 1s gives parity 1. A word with twelve 1s gives parity 0.
- R4: With `par_en_i`=0, the parity bit (status bit 4) is 0 whatever the word.
- R5: With `par_en_i`=1 and `sta_en_i`=0, the parity bit is forced to 0 and only 24 bits are sent. Falling serial clock edges after the last bit of a frame drive `sdo_o` to 0.
- R6: Data bits plus parity bit detect a single flipped bit, which gives an odd count of 1s. Two flipped bits give an even count and go undetected.
- R7: The word, not-ready flag, channel and mode bits are captured on the cycle the block is selected. Changes to them during the read do not alter the frame.
- R8: Raising `cs_n_i` aborts the read. `sdo_oe_o` and `sdo_o` are 0 on the next cycle, and the bit counter returns to zero, so the next read starts again at the MSB.
- R9: `sdo_oe_o` rises one `clk` cycle after `cs_n_i` is seen low and falls one cycle after it is seen high. `drdy_o` is 1 exactly when `conv_nrdy_i`=0 and `sdo_oe_o`=0.
- R10: During and directly after reset, `sdo_oe_o`=0 and `sdo_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_word_i | input | 24 | Latched conversion result |
| conv_nrdy_i | input | 1 | Not-ready flag of the conversion (1 = no fresh result) |
| conv_chan_i | input | 4 | Channel index that produced the result |
| par_en_i | input | 1 | Parity generation enable |
| sta_en_i | input | 1 | Append status byte to each read |
| sclk_i | input | 1 | Host serial clock, idles high |
| cs_n_i | input | 1 | Host select, active low |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| drdy_o | output | 1 | Result waiting and no read in progress |

## Verification
A wrong bit counter or a stale snapshot shows on `sdo_o` at the very bit where it goes wrong. That bit appears one `clk` after the falling serial edge that should have produced it, so the bench compares every shifted bit against a queue built from the inputs seen at selection. A wrong parity term shows only in the status byte, 28 bits into the read. The bench therefore checks the count of 1s over the received frame and reproduces the one-flip and two-flip cases on the received bits. Output-enable and data-ready mistakes show within one `clk` of a select edge and are compared on every clock.

// File: rtl/rdout_pkg.sv
package rdout_pkg;

    localparam int WORD_W  = 24;
    localparam int CHAN_W  = 4;
    localparam int STAT_W  = 8;
    localparam int FRAME_W = WORD_W + STAT_W;

    typedef struct packed {
        logic              not_ready;
        logic [1:0]        rsvd;
        logic              parity;
        logic [CHAN_W-1:0] chan;
    } status_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        status_t           stat;
    } frame_t;

    function automatic logic odd_ones(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

    function automatic status_t make_status(input logic nrdy,
                                            input logic [CHAN_W-1:0] ch,
                                            input logic par);
        status_t s;
        s.not_ready = nrdy;
        s.rsvd      = 2'b00;
        s.parity    = par;
        s.chan      = ch;
        return s;
    endfunction

endpackage

// File: rtl/rdout_edges.sv
module rdout_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    output logic sel_o,
    output logic fall_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_i;
    end

    assign fall_o = sclk_q & ~sclk_i;
    assign sel_o  = ~cs_n_i;

    // R1: a falling edge is a single-cycle strobe
    a_r1_fall_single: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/rdout_capture.sv
module rdout_capture
    import rdout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              nrdy_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              par_en_i,
    input  logic              sta_en_i,
    output frame_t            frame_o,
    output logic              long_o
);
    frame_t frame_q;
    logic   long_q;
    logic   par_d;

    assign par_d = par_en_i & sta_en_i & odd_ones(word_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            long_q  <= 1'b0;
        end else if (take_i) begin
            frame_q.word <= word_i;
            frame_q.stat <= make_status(nrdy_i, chan_i, par_d);
            long_q       <= sta_en_i;
        end
    end

    assign frame_o = frame_q;
    assign long_o  = long_q;

    // R3: captured data plus parity carry an even count of ones
    a_r3_even_total: assert property (@(posedge clk) disable iff (rst)
        (take_i && par_en_i && sta_en_i) |=>
            ((($countones(frame_q.word) + int'(frame_q.stat.parity)) % 2) == 0));

    // R5: parity without status append yields a short frame and a zero parity bit
    a_r5_short_frame: assert property (@(posedge clk) disable iff (rst)
        (take_i && !sta_en_i) |=> (!long_q && !frame_q.stat.parity));

    // R7: snapshot holds until the next selection
    a_r7_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> $stable(frame_q));

endmodule

// File: rtl/rdout_shifter.sv
module rdout_shifter #(
    parameter int FRAME_W = 32,
    parameter int SHORT_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_i,
    input  logic               fall_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               long_i,
    output logic               take_o,
    output logic               oe_o,
    output logic               sdo_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic             active_q;
    logic             sdo_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] len;
    logic [FRAME_W-1:0] aligned;

    assign len     = long_i ? CNT_W'(FRAME_W) : CNT_W'(SHORT_W);
    assign aligned = frame_i << idx_q;
    assign take_o  = sel_i & ~active_q;

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            sdo_q    <= 1'b0;
        end else if (!active_q) begin
            active_q <= 1'b1;
        end else if (fall_i) begin
            if (idx_q < len) begin
                sdo_q <= aligned[FRAME_W-1];
                idx_q <= idx_q + 1'b1;
            end else begin
                sdo_q <= 1'b0;
            end
        end
    end

    assign oe_o  = active_q;
    assign sdo_o = sdo_q;

    // R8: deselect clears the enable and the counter on the next cycle
    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> (!oe_o && idx_q == '0 && !sdo_o));

    // R1: the counter never runs past the frame length
    a_r1_idx_bound: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (idx_q <= len));

    // R5: edges past the end of the frame drive zero
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_i && active_q && fall_i && idx_q >= len) |=> !sdo_o);

endmodule

// File: rtl/rdout_serializer.sv
module rdout_serializer
    import rdout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] conv_word_i,
    input  logic              conv_nrdy_i,
    input  logic [CHAN_W-1:0] conv_chan_i,
    input  logic              par_en_i,
    input  logic              sta_en_i,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              drdy_o
);
    logic   sel;
    logic   fall;
    logic   take;
    logic   long_frame;
    frame_t frame;

    rdout_edges u_edges (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .cs_n_i (cs_n_i),
        .sel_o  (sel),
        .fall_o (fall)
    );

    rdout_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .take_i   (take),
        .word_i   (conv_word_i),
        .nrdy_i   (conv_nrdy_i),
        .chan_i   (conv_chan_i),
        .par_en_i (par_en_i),
        .sta_en_i (sta_en_i),
        .frame_o  (frame),
        .long_o   (long_frame)
    );

    rdout_shifter #(
        .FRAME_W (FRAME_W),
        .SHORT_W (WORD_W)
    ) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (sel),
        .fall_i  (fall),
        .frame_i (frame),
        .long_i  (long_frame),
        .take_o  (take),
        .oe_o    (sdo_oe_o),
        .sdo_o   (sdo_o)
    );

    assign drdy_o = ~conv_nrdy_i & ~sdo_oe_o;

    // R9: data-ready is never shown while a read is in progress
    a_r9_drdy_quiet: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> !drdy_o);

    // R10: outputs idle right after reset
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!sdo_oe_o && !sdo_o));

endmodule

// File: tb/rdout_serializer_tb_top.sv
module rdout_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] conv_word_i = '0;
    logic        conv_nrdy_i = 1'b1;
    logic [3:0]  conv_chan_i = '0;
    logic        par_en_i = 1'b0;
    logic        sta_en_i = 1'b0;
    logic        sclk_i = 1'b1;
    logic        cs_n_i = 1'b1;
    logic        sdo_o, sdo_oe_o, drdy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit model_oe = 0;
    bit exp_q[$];
    logic [31:0] rx;

    always #5 clk = ~clk;

    rdout_serializer dut_i (
        .clk(clk), .rst(rst), .conv_word_i(conv_word_i), .conv_nrdy_i(conv_nrdy_i),
        .conv_chan_i(conv_chan_i), .par_en_i(par_en_i), .sta_en_i(sta_en_i),
        .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .drdy_o(drdy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R9 model: enable follows select one clock late
    always @(posedge clk) model_oe <= !rst && !cs_n_i;

    always @(negedge clk) if (!rst && !done) begin
        check(sdo_oe_o == model_oe, "R9 oe", sdo_oe_o, model_oe);
        check(drdy_o == (!conv_nrdy_i && !model_oe), "R9 drdy", drdy_o,
              !conv_nrdy_i && !model_oe);
    end

    task automatic start(input logic [23:0] w, input bit nrdy, input logic [3:0] ch,
                         input bit pe, input bit se);
        @(negedge clk);
        conv_word_i = w; conv_nrdy_i = nrdy; conv_chan_i = ch;
        par_en_i = pe; sta_en_i = se;
        exp_q.delete();
        for (int i = 23; i >= 0; i--) exp_q.push_back(w[i]);
        if (se) begin
            exp_q.push_back(nrdy);
            exp_q.push_back(1'b0);
            exp_q.push_back(1'b0);
            exp_q.push_back(pe ? ^w : 1'b0);
            for (int i = 3; i >= 0; i--) exp_q.push_back(ch[i]);
        end
        cs_n_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            bit e;
            sclk_i = 1'b0;
            repeat (3) @(negedge clk);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            rx = {rx[30:0], sdo_o};
            check(sdo_o === e, req, sdo_o, e);
            sclk_i = 1'b1;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic stop();
        @(negedge clk);
        cs_n_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic int ones_with_par(input logic [31:0] f);
        return $countones(f[31:8]) + int'(f[4]);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(sdo_oe_o == 0 && sdo_o == 0, "R10 reset idle", {sdo_oe_o, sdo_o}, 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(sdo_oe_o == 0 && sdo_o == 0, "R10 after reset", {sdo_oe_o, sdo_o}, 0);

        // R1 plain 24-bit read, MSB first
        start(24'hA5C3_1E, 1'b0, 4'h3, 1'b0, 1'b0);
        shift(24, "R1 data bit");
        shift(2, "R5 tail zero");
        stop();

        // R2 R3 eleven ones -> parity 1
        start(24'h0007FF, 1'b0, 4'hA, 1'b1, 1'b1);
        shift(32, "R2 R3 frame bit");
        check(rx[4] == 1'b1, "R3 parity eleven ones", rx[4], 1);
        check(ones_with_par(rx) % 2 == 0, "R3 even total", ones_with_par(rx), 0);
        // R6 single flip detected, double flip missed
        check(ones_with_par(rx ^ 32'h0000_0100) % 2 == 1, "R6 one flip",
              ones_with_par(rx ^ 32'h0000_0100) % 2, 1);
        check(ones_with_par(rx ^ 32'h0101_0000) % 2 == 0, "R6 two flips",
              ones_with_par(rx ^ 32'h0101_0000) % 2, 0);
        stop();

        // R3 twelve ones -> parity 0, not-ready flag set
        start(24'h000FFF, 1'b1, 4'h5, 1'b1, 1'b1);
        shift(32, "R2 R3 frame bit");
        check(rx[4] == 1'b0 && rx[7] == 1'b1, "R3 R2 status", rx[7:0], {1'b1, 7'h05});
        stop();

        // R4 append without parity
        start(24'h0007FF, 1'b0, 4'hF, 1'b0, 1'b1);
        shift(32, "R4 frame bit");
        check(rx[4] == 1'b0, "R4 parity off", rx[4], 0);
        stop();

        // R5 parity without append: 24 bits then zeros
        start(24'h0007FF, 1'b0, 4'h1, 1'b1, 1'b0);
        shift(24, "R5 data bit");
        shift(8, "R5 tail zero");
        stop();

        // R7 inputs change mid-read
        start(24'hF0F0F0, 1'b0, 4'h6, 1'b1, 1'b1);
        shift(5, "R7 bit");
        conv_word_i = 24'h0F0F0F; conv_chan_i = 4'h9; conv_nrdy_i = 1'b1;
        par_en_i = 1'b0; sta_en_i = 1'b0;
        shift(27, "R7 snapshot bit");
        stop();

        // R8 abort mid-read, restart from MSB
        start(24'h123456, 1'b0, 4'h2, 1'b0, 1'b1);
        shift(10, "R8 pre-abort bit");
        @(negedge clk) cs_n_i = 1'b1;
        @(negedge clk);
        check(sdo_oe_o == 0 && sdo_o == 0, "R8 abort", {sdo_oe_o, sdo_o}, 0);
        start(24'h800001, 1'b0, 4'h4, 1'b1, 1'b1);
        shift(32, "R8 restart bit");
        stop();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule